// File: doc/BRIEF.md
# Privilege-Aware Virtual Segment Classifier

This block sits in front of the translation lookaside buffer of a 64-bit processor. Each cycle it looks at a virtual address together with the current privilege level, the error-level flag and the three 64-bit addressing enables (user, supervisor, kernel). It decides which of three outcomes applies to the access:

- the access must be translated by the TLB;
- the access goes straight to a physical address, which the block computes;
- the access is illegal and raises an address error, with the error reported separately for loads and for stores.

How far each extended region reaches is not fixed. It is set by a segment-size mask and a physical-address mask, both supplied at run time. The decision and the physical address come out of one register stage. The TLB lookup, cache attributes and exception delivery are left to the logic around the block.

Top module: `vseg_classifier`

## Requirements
- R1: During and directly after a synchronous active-high reset, `result_o` is 0 (no decision), `paddr_o` is 0 and both error flags are low. The result codes are: 1 = mapped, 2 = unmapped, 3 = address error.
- R2: `mode_i` = 2'b10 is user and 2'b01 is supervisor. Both 2'b00 and 2'b11 are kernel.
- R3: Addresses 0 to 0x7FFF_FFFF are mapped in every mode when `erl_i` is low. When `erl_i` is high they are unmapped, and the physical address is the low 32 bits of the address.
- R4: Addresses from 0x8000_0000 to 0x3FFF_FFFF_FFFF_FFFF are mapped in any mode if `ux_i` is high and the address is no larger than 0x3FFF_FFFF_FFFF_FFFF AND `segmask_i`. Otherwise they are an error.
- R5: Addresses with top bits 2'b01 are mapped only if the mode is not user, `sx_i` is high, and the address is no larger than 0x7FFF_FFFF_FFFF_FFFF AND `segmask_i`. Otherwise they are an error.
- R6: Addresses with top bits 2'b10 are unmapped only if the mode is kernel, `kx_i` is high, and (address AND 0x07FF_FFFF_FFFF_FFFF) is no larger than `pamask_i`. In that case the physical address is the address AND `pamask_i`. Otherwise they are an error.
- R7: Addresses from 0xC000_0000_0000_0000 to 0xFFFF_FFFF_7FFF_FFFF are mapped only if the mode is kernel, `kx_i` is high, and the address is no larger than 0xFFFF_FFFF_7FFF_FFFF AND `segmask_i`. Otherwise they are an error.
- R8: Addresses from 0xFFFF_FFFF_8000_0000 to 0xFFFF_FFFF_BFFF_FFFF are unmapped in kernel mode, with physical address equal to address bits 28:0. In other modes they are an error.
- R9: Addresses from 0xFFFF_FFFF_C000_0000 to 0xFFFF_FFFF_DFFF_FFFF are mapped in supervisor and kernel modes. Addresses from 0xFFFF_FFFF_E000_0000 upward are mapped in kernel mode only. All other cases in these two ranges are an error.
- R10: An error result raises `err_store_o` when `store_i` is high and `err_load_o` when it is low. The two flags are never high together. `paddr_o` is 0 whenever the result is not unmapped.
- R11: Every output reflects the inputs sampled at the previous rising clock edge. There is exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vaddr_i | input | 64 | Virtual address |
| mode_i | input | 2 | Privilege level field |
| erl_i | input | 1 | Error-level flag |
| ux_i | input | 1 | User 64-bit addressing enable |
| sx_i | input | 1 | Supervisor 64-bit addressing enable |
| kx_i | input | 1 | Kernel 64-bit addressing enable |
| store_i | input | 1 | Access is a store (else load) |
| segmask_i | input | 64 | Segment-size mask |
| pamask_i | input | PA_W | Physical-address mask |
| result_o | output | 2 | Decision code |
| paddr_o | output | PA_W | Physical address for unmapped accesses |
| err_load_o | output | 1 | Address error on a load |
| err_store_o | output | 1 | Address error on a store |

## Verification
Every result (decision code, physical address and both error flags) is due at the first rising edge after its inputs are applied, and none comes later. The bench drives each stimulus on a falling edge and reads all four outputs on the next falling edge. That point is half a period after the capturing edge and before any later input can reach the register. The reset values are read the same way, while reset is still held high.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  localparam int VA_W = 64;

  typedef enum logic [1:0] {
    RES_NONE     = 2'd0,
    RES_MAPPED   = 2'd1,
    RES_UNMAPPED = 2'd2,
    RES_ERROR    = 2'd3
  } vseg_res_e;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_KERN = 2'd2
  } vseg_priv_e;

  typedef enum logic [2:0] {
    RGN_LOW     = 3'd0,
    RGN_XUSER   = 3'd1,
    RGN_XSUP    = 3'd2,
    RGN_XPHYS   = 3'd3,
    RGN_XKERN   = 3'd4,
    RGN_CDIRECT = 3'd5,
    RGN_CSUP    = 3'd6,
    RGN_CKERN   = 3'd7
  } vseg_rgn_e;

  localparam logic [VA_W-1:0] XUSER_TOP  = 64'h3FFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] XSUP_TOP   = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [VA_W-1:0] XKERN_TOP  = 64'hFFFF_FFFF_7FFF_FFFF;
  localparam logic [VA_W-1:0] XPHYS_OFFS = 64'h07FF_FFFF_FFFF_FFFF;

  function automatic vseg_priv_e decode_priv(input logic [1:0] fld);
    case (fld)
      2'b10:   return PRIV_USER;
      2'b01:   return PRIV_SUP;
      default: return PRIV_KERN;
    endcase
  endfunction

endpackage

// File: rtl/vseg_region.sv
module vseg_region
  import vseg_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  output vseg_rgn_e       region
);

  logic low_zero;
  logic high_ones;

  assign low_zero  = (vaddr[VA_W-1:31] == '0);
  assign high_ones = &vaddr[VA_W-1:31];

  always_comb begin
    region = RGN_LOW;
    if (!low_zero) begin
      case (vaddr[VA_W-1:VA_W-2])
        2'b00: region = RGN_XUSER;
        2'b01: region = RGN_XSUP;
        2'b10: region = RGN_XPHYS;
        default: begin
          if (!high_ones) begin
            region = RGN_XKERN;
          end else begin
            case (vaddr[30:29])
              2'b10:   region = RGN_CSUP;
              2'b11:   region = RGN_CKERN;
              default: region = RGN_CDIRECT;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vseg_rules.sv
module vseg_rules
  import vseg_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic [VA_W-1:0] vaddr,
  input  vseg_rgn_e       region,
  input  vseg_priv_e      priv,
  input  logic            erl,
  input  logic            ux,
  input  logic            sx,
  input  logic            kx,
  input  logic [VA_W-1:0] segmask,
  input  logic [PA_W-1:0] pamask,
  output vseg_res_e       res,
  output logic [PA_W-1:0] phys
);

  localparam int PAD_W = VA_W - PA_W;

  logic [VA_W-1:0] pamask_ext;
  logic            is_kern;
  logic            not_user;

  assign pamask_ext = {{PAD_W{1'b0}}, pamask};
  assign is_kern    = (priv == PRIV_KERN);
  assign not_user   = (priv != PRIV_USER);

  always_comb begin
    res  = RES_ERROR;
    phys = '0;
    case (region)
      RGN_LOW: begin
        if (erl) begin
          res  = RES_UNMAPPED;
          phys = PA_W'(vaddr[31:0]);
        end else begin
          res = RES_MAPPED;
        end
      end
      RGN_XUSER: begin
        if (ux && (vaddr <= (XUSER_TOP & segmask))) res = RES_MAPPED;
      end
      RGN_XSUP: begin
        if (not_user && sx && (vaddr <= (XSUP_TOP & segmask))) res = RES_MAPPED;
      end
      RGN_XPHYS: begin
        if (is_kern && kx && ((vaddr & XPHYS_OFFS) <= pamask_ext)) begin
          res  = RES_UNMAPPED;
          phys = vaddr[PA_W-1:0] & pamask;
        end
      end
      RGN_XKERN: begin
        if (is_kern && kx && (vaddr <= (XKERN_TOP & segmask))) res = RES_MAPPED;
      end
      RGN_CDIRECT: begin
        if (is_kern) begin
          res  = RES_UNMAPPED;
          phys = PA_W'(vaddr[28:0]);
        end
      end
      RGN_CSUP: begin
        if (not_user) res = RES_MAPPED;
      end
      default: begin
        if (is_kern) res = RES_MAPPED;
      end
    endcase
  end

endmodule

// File: rtl/vseg_classifier.sv
module vseg_classifier
  import vseg_pkg::*;
#(
  parameter int PA_W = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [63:0]     vaddr_i,
  input  logic [1:0]      mode_i,
  input  logic            erl_i,
  input  logic            ux_i,
  input  logic            sx_i,
  input  logic            kx_i,
  input  logic            store_i,
  input  logic [63:0]     segmask_i,
  input  logic [PA_W-1:0] pamask_i,
  output logic [1:0]      result_o,
  output logic [PA_W-1:0] paddr_o,
  output logic            err_load_o,
  output logic            err_store_o
);

  vseg_rgn_e       rgn;
  vseg_priv_e      priv;
  vseg_res_e       res_c;
  logic [PA_W-1:0] phys_c;
  logic            is_err_c;

  assign priv     = decode_priv(mode_i);
  assign is_err_c = (res_c == RES_ERROR);

  vseg_region u_region (
    .vaddr  (vaddr_i),
    .region (rgn)
  );

  vseg_rules #(.PA_W(PA_W)) u_rules (
    .vaddr   (vaddr_i),
    .region  (rgn),
    .priv    (priv),
    .erl     (erl_i),
    .ux      (ux_i),
    .sx      (sx_i),
    .kx      (kx_i),
    .segmask (segmask_i),
    .pamask  (pamask_i),
    .res     (res_c),
    .phys    (phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o    <= RES_NONE;
      paddr_o     <= '0;
      err_load_o  <= 1'b0;
      err_store_o <= 1'b0;
    end else begin
      result_o    <= res_c;
      paddr_o     <= phys_c;
      err_load_o  <= is_err_c && !store_i;
      err_store_o <= is_err_c && store_i;
    end
  end

  // R10: load and store errors are exclusive
  a_r10_err_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(err_load_o && err_store_o));

  // R10: the physical bus is quiet unless the access is unmapped
  a_r10_paddr_quiet: assert property (@(posedge clk) disable iff (rst)
    (result_o != RES_UNMAPPED) |-> (paddr_o == '0));

  // R10: the store flag follows the access type of the erroring request
  a_r10_store_flag: assert property (@(posedge clk) disable iff (rst)
    (store_i && is_err_c) |=> err_store_o);

  // R2: user mode without the error-level flag never reaches a direct window
  a_r2_user_no_direct: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && !erl_i) |=> (result_o != RES_UNMAPPED));

  // R11: a decision is present one cycle after any non-reset cycle
  a_r11_decision_due: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (result_o != RES_NONE));

endmodule

// File: tb/vseg_classifier_tb.sv
module vseg_classifier_tb;

  localparam int PA_W = 48;
  localparam time CLK_PERIOD = 10;
  localparam logic [1:0] MU = 2'b10, MS = 2'b01, MK = 2'b00, MK2 = 2'b11;
  localparam logic [63:0] SEGM = 64'hC000_00FF_FFFF_FFFF;
  localparam logic [PA_W-1:0] PAM = 48'h0000_000F_FFFF_FFFF;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [63:0]     vaddr = '0;
  logic [1:0]      mode = MK;
  logic            erl = 1'b0, ux = 1'b0, sx = 1'b0, kx = 1'b0, store = 1'b0;
  logic [63:0]     segmask = SEGM;
  logic [PA_W-1:0] pamask = PAM;
  logic [1:0]      result;
  logic [PA_W-1:0] paddr;
  logic            err_ld, err_st;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vseg_classifier #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst(rst), .vaddr_i(vaddr), .mode_i(mode), .erl_i(erl),
    .ux_i(ux), .sx_i(sx), .kx_i(kx), .store_i(store), .segmask_i(segmask),
    .pamask_i(pamask), .result_o(result), .paddr_o(paddr),
    .err_load_o(err_ld), .err_store_o(err_st)
  );

  task automatic expect_out(input string req, input logic [1:0] r,
                            input logic [PA_W-1:0] p, input logic el, input logic es);
    checks++;
    if (result !== r || paddr !== p || err_ld !== el || err_st !== es) begin
      errors++;
      $display("FAIL %s: got res=%0d pa=%h ld=%0b st=%0b exp res=%0d pa=%h ld=%0b st=%0b",
               req, result, paddr, err_ld, err_st, r, p, el, es);
    end
  endtask

  // drive on a falling edge, read on the next falling edge (one register)
  task automatic apply(input logic [63:0] a, input logic [1:0] m, input logic e,
                       input logic u, input logic s, input logic k, input logic st);
    vaddr = a; mode = m; erl = e; ux = u; sx = s; kx = k; store = st;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_out("R1", 2'd0, '0, 1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_low();
    apply(64'h1234_5678, MU, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 mapped", 2'd1, '0, 1'b0, 1'b0);
    apply(64'h1234_5678, MU, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R3 erl", 2'd2, 48'h0000_1234_5678, 1'b0, 1'b0);
  endtask

  task automatic t_xuser();
    apply(64'h0000_0010_0000_0000, MU, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R4 inside", 2'd1, '0, 1'b0, 1'b0);
    apply(64'h0000_0100_0000_0000, MU, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R4 beyond segmask", 2'd3, '0, 1'b1, 1'b0);
    apply(64'h0000_0001_0000_0000, MU, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R4 ux off store R10", 2'd3, '0, 1'b0, 1'b1);
  endtask

  task automatic t_xsup();
    apply(64'h4000_0000_0000_1000, MS, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 sup", 2'd1, '0, 1'b0, 1'b0);
    apply(64'h4000_0000_0000_1000, MU, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 user", 2'd3, '0, 1'b1, 1'b0);
    apply(64'h4000_0000_0000_1000, MK2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R2 mode 11 kernel", 2'd1, '0, 1'b0, 1'b0);
    apply(64'h4000_0100_0000_0000, MS, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R5 beyond segmask", 2'd3, '0, 1'b1, 1'b0);
  endtask

  task automatic t_xphys();
    apply(64'h9000_0000_1234_5000, MK, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R6 direct", 2'd2, 48'h0000_1234_5000, 1'b0, 1'b0);
    apply(64'h9000_0010_0000_0000, MK, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R6 above pamask", 2'd3, '0, 1'b1, 1'b0);
    apply(64'h9000_0000_1234_5000, MK, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R6 kx off", 2'd3, '0, 1'b1, 1'b0);
    apply(64'h9000_0000_1234_5000, MS, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R6 supervisor", 2'd3, '0, 1'b1, 1'b0);
  endtask

  task automatic t_xkern();
    apply(64'hC000_0000_0000_2000, MK, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    expect_out("R7 inside", 2'd1, '0, 1'b0, 1'b0);
    apply(64'hC000_0100_0000_0000, MK, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    expect_out("R7 beyond segmask", 2'd3, '0, 1'b0, 1'b1);
    apply(64'hFFFF_FFFF_0000_0000, MS, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R7 supervisor", 2'd3, '0, 1'b1, 1'b0);
  endtask

  task automatic t_compat();
    apply(64'hFFFF_FFFF_8123_4560, MK, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R8 cached window", 2'd2, 48'h0000_0123_4560, 1'b0, 1'b0);
    apply(64'hFFFF_FFFF_A000_0040, MK2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R8 uncached window", 2'd2, 48'h0000_0000_0040, 1'b0, 1'b0);
    apply(64'hFFFF_FFFF_8000_0000, MU, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R8 user", 2'd3, '0, 1'b1, 1'b0);
    apply(64'hFFFF_FFFF_C000_0000, MS, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R9 sup window", 2'd1, '0, 1'b0, 1'b0);
    apply(64'hFFFF_FFFF_C000_0000, MU, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R9 user", 2'd3, '0, 1'b0, 1'b1);
    apply(64'hFFFF_FFFF_E000_0000, MS, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R9 top sup", 2'd3, '0, 1'b1, 1'b0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, MK, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R9 top kernel", 2'd1, '0, 1'b0, 1'b0);
  endtask

  task automatic t_latency();
    vaddr = 64'hFFFF_FFFF_8000_0010; mode = MK; erl = 1'b0; store = 1'b0;
    @(posedge clk);
    #1;
    vaddr = 64'h0000_0001_0000_0000; ux = 1'b0; store = 1'b1;
    @(negedge clk);
    expect_out("R11 holds captured", 2'd2, 48'h10, 1'b0, 1'b0);
    @(negedge clk);
    expect_out("R11 next", 2'd3, '0, 1'b0, 1'b1);
  endtask

  initial begin
    t_reset();
    t_low();
    t_xuser();
    t_xsup();
    t_xphys();
    t_xkern();
    t_compat();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule